// File: doc/BRIEF.md
# Dual-Source Reset Register Controller

This block holds the direct configuration registers of a data-path device and reacts to two reset sources. An active-low hardware reset pin clears every direct register. A self-clearing software reset bit clears the same registers except the bridge-mode register, which only the pin clears. A small indirectly addressed storage array, reached through an address register and a data register, is never cleared by either reset. The host must load it explicitly after power-up.

After either reset, a settling timer keeps the `port_ready` output low for 0.625 ms, with the duration computed from the clock-frequency parameter. Downstream packet logic must not accept data until `port_ready` rises. The global receive and transmit DMA enables come straight from one configuration register, so both are off after any reset.

Host accesses are single-cycle strobes. A write takes effect at the clock edge that samples it. A read returns its data on `host_rdata` with `host_rd_valid` high one cycle after the read strobe. The address map is CTRL=0, MCFG=1, GEN=2, BRIDGE=3, IADDR=4, IDATA=5. Unmapped addresses read as zero.

Top module: `rstctl_top`

## Requirements
- R1: While `rst_hw_n` is low, and after it is released, MCFG, GEN, BRIDGE and IADDR read 0000h, and `bridge_mode` is 0.
- R2: Writing address 0 with bit 0 set produces a one-cycle internal reset in the following cycle. That reset clears MCFG, GEN and IADDR. CTRL bit 0 then reads back 0.
- R3: BRIDGE (address 3) keeps its value through a software reset.
- R4: Entries of the indirect storage keep their contents through software and hardware resets.
- R5: Writing IDATA (address 5) stores the data into the entry selected by IADDR (address 4). Reading IDATA returns that entry. Every read drives `host_rdata` and asserts `host_rd_valid` exactly one cycle after `host_rd_en`.
- R6: `rx_dma_en` follows MCFG bit 0 and `tx_dma_en` follows MCFG bit 1. Both are 0 after either reset.
- R7: `port_ready` is low after any reset. It rises after exactly CLK_HZ×0.000625 clock edges. For a hardware reset, the count starts at the second edge after `rst_hw_n` rises. For a software reset, it starts at the edge that applies the internal reset.
- R8: Driving `rst_hw_n` low clears the registers and `port_ready` at once, without waiting for a clock edge. Release is delayed by a two-stage synchronizer.
- R9: A write to address 0 with bit 0 clear has no effect. Configuration stays as it was, and `port_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_hw_n | input | 1 | Hardware reset, active low, asynchronous assert |
| host_wr_en | input | 1 | Host write strobe |
| host_rd_en | input | 1 | Host read strobe |
| host_addr | input | 4 | Register address |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, valid with host_rd_valid |
| host_rd_valid | output | 1 | Read data valid, one cycle after host_rd_en |
| rx_dma_en | output | 1 | Global receive DMA enable (MCFG bit 0) |
| tx_dma_en | output | 1 | Global transmit DMA enable (MCFG bit 1) |
| bridge_mode | output | 16 | Bridge-mode register contents |
| port_ready | output | 1 | High once the post-reset settling time has elapsed |

## Verification
If the software reset pulse were lost or stretched, the effect would show on the next register read or on the DMA enable pins within two cycles. If the pulse reached the bridge register, `bridge_mode` would drop to zero on the same edge. A timer that restarts at the wrong moment moves the `port_ready` rising edge by a whole number of cycles, so the bench samples that edge exactly at the expected cycle and one cycle earlier. If the indirect array were reset, or written at the wrong entry, later reads of a distinct pattern per entry would return a wrong value.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 16;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL   = 4'd0,
    RA_MCFG   = 4'd1,
    RA_GEN    = 4'd2,
    RA_BRIDGE = 4'd3,
    RA_IADDR  = 4'd4,
    RA_IDATA  = 4'd5
  } reg_addr_e;

  localparam int unsigned CTRL_SWRST_BIT = 0;
  localparam int unsigned MCFG_RXDMA_BIT = 0;
  localparam int unsigned MCFG_TXDMA_BIT = 1;
endpackage

// File: rtl/rstctl_rst_sync.sv
module rstctl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];

  // R8
  sync_assert_chk: assert property (@(posedge clk) !arst_n |-> !rst_n_o);
endmodule

// File: rtl/rstctl_ready_timer.sv
module rstctl_ready_timer #(
  parameter int unsigned CLK_HZ     = 100_000_000,
  parameter int unsigned SETTLE_NUM = 625,
  parameter int unsigned SETTLE_DEN = 1_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic ready_o
);
  localparam longint unsigned CYC64 = (64'(CLK_HZ) * 64'(SETTLE_NUM)) / 64'(SETTLE_DEN);
  localparam int unsigned READY_CYCLES = (CYC64 < 64'd1) ? 1 : 32'(CYC64);
  localparam int unsigned CNT_W = $clog2(READY_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             done;

  assign done = (cnt_q == CNT_W'(READY_CYCLES));

  always_comb begin
    cnt_d = cnt_q;
    if (restart_i)  cnt_d = '0;
    else if (!done) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign ready_o = done;

  // R7
  restart_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> !ready_o);
  // R7
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && !restart_i) |=> ready_o);
endmodule

// File: rtl/rstctl_ind_store.sv
module rstctl_ind_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/rstctl_top.sv
module rstctl_top
  import rstctl_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 100_000_000,
  parameter int unsigned IND_DEPTH = 16,
  localparam int unsigned IND_AW   = $clog2(IND_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_hw_n,
  input  logic              host_wr_en,
  input  logic              host_rd_en,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rd_valid,
  output logic              rx_dma_en,
  output logic              tx_dma_en,
  output logic [DATA_W-1:0] bridge_mode,
  output logic              port_ready
);
  logic rst_n;

  logic              swrst_q,  swrst_d;
  logic [DATA_W-1:0] mcfg_q,   mcfg_d;
  logic [DATA_W-1:0] gen_q,    gen_d;
  logic [DATA_W-1:0] bridge_q, bridge_d;
  logic [IND_AW-1:0] iaddr_q,  iaddr_d;
  logic [DATA_W-1:0] rdata_q,  rdata_d;
  logic              rvalid_q, rvalid_d;
  logic              ind_we;
  logic [DATA_W-1:0] ind_rdata;

  rstctl_rst_sync #(.STAGES(2)) u_sync (
    .clk     (clk),
    .arst_n  (rst_hw_n),
    .rst_n_o (rst_n)
  );

  rstctl_ready_timer #(.CLK_HZ(CLK_HZ)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (swrst_q),
    .ready_o   (port_ready)
  );

  assign ind_we = rst_n && host_wr_en && (host_addr == RA_IDATA);

  rstctl_ind_store #(.DEPTH(IND_DEPTH), .WIDTH(DATA_W)) u_store (
    .clk     (clk),
    .we_i    (ind_we),
    .addr_i  (iaddr_q),
    .wdata_i (host_wdata),
    .rdata_o (ind_rdata)
  );

  // next state
  always_comb begin
    swrst_d  = host_wr_en && (host_addr == RA_CTRL) &&
               host_wdata[CTRL_SWRST_BIT] && !swrst_q;
    mcfg_d   = mcfg_q;
    gen_d    = gen_q;
    iaddr_d  = iaddr_q;
    bridge_d = bridge_q;
    if (host_wr_en && (host_addr == RA_BRIDGE)) bridge_d = host_wdata;
    if (swrst_q) begin
      mcfg_d  = '0;
      gen_d   = '0;
      iaddr_d = '0;
    end else if (host_wr_en) begin
      case (host_addr)
        RA_MCFG:  mcfg_d  = host_wdata;
        RA_GEN:   gen_d   = host_wdata;
        RA_IADDR: iaddr_d = host_wdata[IND_AW-1:0];
        default:  ;
      endcase
    end

    rvalid_d = host_rd_en;
    rdata_d  = '0;
    if (host_rd_en) begin
      case (host_addr)
        RA_CTRL:   rdata_d = DATA_W'(swrst_q);
        RA_MCFG:   rdata_d = mcfg_q;
        RA_GEN:    rdata_d = gen_q;
        RA_BRIDGE: rdata_d = bridge_q;
        RA_IADDR:  rdata_d = DATA_W'(iaddr_q);
        RA_IDATA:  rdata_d = ind_rdata;
        default:   rdata_d = '0;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swrst_q  <= 1'b0;
      mcfg_q   <= '0;
      gen_q    <= '0;
      bridge_q <= '0;
      iaddr_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      swrst_q  <= swrst_d;
      mcfg_q   <= mcfg_d;
      gen_q    <= gen_d;
      bridge_q <= bridge_d;
      iaddr_q  <= iaddr_d;
      rdata_q  <= rdata_d;
      rvalid_q <= rvalid_d;
    end
  end

  assign host_rdata    = rdata_q;
  assign host_rd_valid = rvalid_q;
  assign rx_dma_en     = mcfg_q[MCFG_RXDMA_BIT];
  assign tx_dma_en     = mcfg_q[MCFG_TXDMA_BIT];
  assign bridge_mode   = bridge_q;

  // R2
  swrst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swrst_q |=> !swrst_q);
  // R2
  swrst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swrst_q |=> (mcfg_q == '0 && gen_q == '0 && iaddr_q == '0));
  // R3
  bridge_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (swrst_q && !(host_wr_en && host_addr == RA_BRIDGE)) |=> $stable(bridge_q));
  // R5
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd_en |=> host_rd_valid);
  // R6
  dma_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swrst_q |=> (!rx_dma_en && !tx_dma_en));
endmodule

// File: tb/rstctl_top_tb.sv
module rstctl_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int unsigned TB_CLK_HZ = 1_600_000;
  localparam int READY = 1000;

  logic        clk = 1'b0;
  logic        rst_hw_n;
  logic        host_wr_en, host_rd_en;
  logic [3:0]  host_addr;
  logic [15:0] host_wdata;
  logic [15:0] host_rdata;
  logic        host_rd_valid, rx_dma_en, tx_dma_en, port_ready;
  logic [15:0] bridge_mode;

  int checks = 0;
  int failures = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rstctl_top #(.CLK_HZ(TB_CLK_HZ), .IND_DEPTH(16)) u_dut (
    .clk(clk), .rst_hw_n(rst_hw_n), .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rd_valid(host_rd_valid), .rx_dma_en(rx_dma_en), .tx_dma_en(tx_dma_en),
    .bridge_mode(bridge_mode), .port_ready(port_ready)
  );

  function automatic logic [15:0] pat(input int k);
    return 16'hC000 ^ 16'(k * 16'h0135);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    host_wr_en = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk);
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    host_rd_en = 1'b1; host_addr = a;
    @(posedge clk);
    @(negedge clk);
    host_rd_en = 1'b0;
    chk("R5 rd_valid", 32'(host_rd_valid), 32'd1);
    d = host_rdata;
  endtask

  task automatic expect_reg(input string tag, input logic [3:0] a, input logic [15:0] e);
    logic [15:0] v;
    do_read(a, v);
    chk(tag, 32'(v), 32'(e));
  endtask

  // R1 R7 R8: hardware reset, release timing of port_ready
  task automatic t_hw_release;
    @(negedge clk);
    rst_hw_n = 1'b0;
    #1;
    chk("R8 async port_ready", 32'(port_ready), 32'd0);
    chk("R8 async bridge", 32'(bridge_mode), 32'd0);
    chk("R6 async dma", 32'({rx_dma_en, tx_dma_en}), 32'd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_hw_n = 1'b1;
    repeat (READY + 1) @(posedge clk);
    @(negedge clk);
    chk("R7 hw ready early", 32'(port_ready), 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R7 hw ready on time", 32'(port_ready), 32'd1);
  endtask

  task automatic t_reset_state;
    expect_reg("R1 MCFG", 4'd1, 16'h0000);
    expect_reg("R1 GEN", 4'd2, 16'h0000);
    expect_reg("R1 BRIDGE", 4'd3, 16'h0000);
    expect_reg("R1 IADDR", 4'd4, 16'h0000);
    chk("R6 dma after reset", 32'({rx_dma_en, tx_dma_en}), 32'd0);
  endtask

  task automatic t_config_rw;
    do_write(4'd1, 16'h0001);
    chk("R6 rx only", 32'({rx_dma_en, tx_dma_en}), 32'b10);
    do_write(4'd1, 16'h0002);
    chk("R6 tx only", 32'({rx_dma_en, tx_dma_en}), 32'b01);
    do_write(4'd1, 16'hF003);
    chk("R6 both", 32'({rx_dma_en, tx_dma_en}), 32'b11);
    do_write(4'd2, 16'hA5C3);
    do_write(4'd3, 16'h3C5A);
    chk("R3 bridge out", 32'(bridge_mode), 32'h3C5A);
    expect_reg("R5 MCFG rb", 4'd1, 16'hF003);
    expect_reg("R5 GEN rb", 4'd2, 16'hA5C3);
    expect_reg("R5 unmapped", 4'd9, 16'h0000);
  endtask

  task automatic t_ind_access;
    for (int k = 0; k < 16; k++) begin
      do_write(4'd4, 16'(k));
      do_write(4'd5, pat(k));
    end
    for (int k = 15; k >= 0; k--) begin
      do_write(4'd4, 16'(k));
      expect_reg("R5 ind read", 4'd5, pat(k));
    end
    do_write(4'd4, 16'd7);
    expect_reg("R5 IADDR rb", 4'd4, 16'd7);
  endtask

  task automatic t_ctrl_noop;
    do_write(4'd0, 16'hFFFE);
    @(negedge clk);
    chk("R9 ready kept", 32'(port_ready), 32'd1);
    expect_reg("R9 MCFG kept", 4'd1, 16'hF003);
    expect_reg("R9 IADDR kept", 4'd4, 16'd7);
  endtask

  task automatic t_sw_reset;
    do_write(4'd0, 16'h0001);
    chk("R2 dma before pulse", 32'(rx_dma_en), 32'd1);
    @(posedge clk);
    @(negedge clk);
    chk("R2 dma cleared", 32'({rx_dma_en, tx_dma_en}), 32'd0);
    chk("R7 sw ready low", 32'(port_ready), 32'd0);
    chk("R3 bridge pin kept", 32'(bridge_mode), 32'h3C5A);
    repeat (READY - 1) @(posedge clk);
    @(negedge clk);
    chk("R7 sw ready early", 32'(port_ready), 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R7 sw ready on time", 32'(port_ready), 32'd1);
    expect_reg("R2 CTRL selfclr", 4'd0, 16'h0000);
    expect_reg("R2 MCFG", 4'd1, 16'h0000);
    expect_reg("R2 GEN", 4'd2, 16'h0000);
    expect_reg("R2 IADDR", 4'd4, 16'h0000);
    expect_reg("R3 BRIDGE", 4'd3, 16'h3C5A);
    for (int k = 0; k < 16; k += 5) begin
      do_write(4'd4, 16'(k));
      expect_reg("R4 ind after sw", 4'd5, pat(k));
    end
  endtask

  task automatic t_hw_reset_keep;
    do_write(4'd1, 16'h0003);
    t_hw_release();
    expect_reg("R1 BRIDGE hw", 4'd3, 16'h0000);
    expect_reg("R1 MCFG hw", 4'd1, 16'h0000);
    for (int k = 2; k < 16; k += 6) begin
      do_write(4'd4, 16'(k));
      expect_reg("R4 ind after hw", 4'd5, pat(k));
    end
  endtask

  initial begin
    rst_hw_n = 1'b0; host_wr_en = 1'b0; host_rd_en = 1'b0;
    host_addr = '0; host_wdata = '0;
    t_hw_release();
    t_reset_state();
    t_config_rw();
    t_ind_access();
    t_ctrl_noop();
    t_sw_reset();
    t_hw_reset_keep();
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule